// File: doc/BRIEF.md
# Usage Fault Status Register

This block keeps a 16-bit record of usage faults reported by a processor's execute stage. Each cycle the execute stage may raise strobes for six kinds of fault:
- a divide whose divisor is zero;
- an unaligned memory access, with a qualifier marking a multi-word transfer;
- an attempt to reach a coprocessor;
- an illegal program-counter load during exception return;
- an illegal use of execution state;
- an undecodable instruction.

Two enable inputs from a configuration register decide whether the divide and unaligned events count as faults. A multi-word unaligned transfer counts regardless of its enable.

Every recorded fault sets a sticky flag. The flag stays set until software writes a one to that bit position, or until reset. Software reads the vector through a simple strobe-based register port.

Alongside the flags, the block drives two outputs. One is a single-cycle pending pulse that the exception logic can take as a usage-fault request. The other is the bit index of the most recently recorded fault.

Top module: `ufault_status`

## Requirements
- R1: Flag positions are fixed. Bit 0 is undefined instruction, bit 1 is invalid execution state, bit 2 is illegal PC load on exception return, bit 3 is coprocessor access, bit 8 is unaligned access and bit 9 is divide by zero.
- R2: Bits 15:10 and 7:4 always read as zero, whatever is written to them.
- R3: A flag, once set, stays 1 across later cycles until it is cleared by a write or by reset.
- R4: A write (`reg_wr` high) with a 1 in a flag position clears only that flag. A 0 in a flag position leaves that flag unchanged.
- R5: A divide-by-zero event sets bit 9 only while `trap_div0_en` is 1.
- R6: An unaligned event sets bit 8 while `trap_unalign_en` is 1. It also sets bit 8 whenever `ev_unalign_multi` is 1, regardless of the enable.
- R7: When the invalid-state and undefined-instruction strobes arrive in the same cycle, only bit 0 is set and bit 1 is left unchanged.
- R8: If a fault event and a write-one clear target the same bit in the same cycle, the bit ends up set.
- R9: `fault_pend` is high for exactly the one cycle after any cycle with a qualifying event. Events ignored because their trap is disabled do not raise it.
- R10: A synchronous active-high reset clears all flags, `fault_pend`, `fault_idx` and `reg_rdata` to zero.
- R11: A read strobe at one clock edge places the flag vector held before that edge on `reg_rdata` in the following cycle. `reg_rdata` then holds until the next read.
- R12: `fault_idx` takes the lowest bit index among the flags set by the events of a cycle, one cycle later. It holds its value in cycles with no qualifying event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_div0 | input | 1 | Divide with zero divisor strobe |
| ev_unalign | input | 1 | Unaligned access strobe |
| ev_unalign_multi | input | 1 | Qualifies the unaligned strobe as a multi-word transfer |
| ev_nocp | input | 1 | Coprocessor access attempt strobe |
| ev_invpc | input | 1 | Illegal PC load on exception return strobe |
| ev_invstate | input | 1 | Illegal execution-state use strobe |
| ev_undef | input | 1 | Undefined instruction strobe |
| trap_div0_en | input | 1 | Enables divide-by-zero faulting |
| trap_unalign_en | input | 1 | Enables single-word unaligned faulting |
| reg_wr | input | 1 | Register write strobe (write-one-to-clear) |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |
| fault_pend | output | 1 | One-cycle usage-fault request |
| fault_idx | output | 4 | Bit index of the newest recorded fault |

## Verification
Each gated source is driven twice: once with its enable low and once with it high. This separates a missing gate from a stuck one, and the multi-word unaligned case shows whether the override bypasses the enable.

Invalid state is driven together with an undefined instruction, and then on its own. This isolates the suppression rule from ordinary setting.

Clears are tried with all ones, with zeros, with only reserved positions, and in the same cycle as a set on the same bit. These four patterns separate the write-one-to-clear rule, the write-zero rule, the reserved mask and the set-over-clear priority.

Simultaneous events check the index encoding. A reset applied with flags set confirms that every output returns to zero.

// File: rtl/ufault_pkg.sv
package ufault_pkg;
  localparam int unsigned UF_W      = 16;
  localparam int unsigned UF_IDX_W  = $clog2(UF_W);
  // Flag positions (decoded by software, so fixed)
  localparam int unsigned B_UNDEF   = 0;
  localparam int unsigned B_INVST   = 1;
  localparam int unsigned B_INVPC   = 2;
  localparam int unsigned B_NOCP    = 3;
  localparam int unsigned B_UNALIGN = 8;
  localparam int unsigned B_DIV0    = 9;
  localparam logic [UF_W-1:0] UF_IMPL_MASK =
    UF_W'((1 << B_UNDEF) | (1 << B_INVST) | (1 << B_INVPC) |
          (1 << B_NOCP) | (1 << B_UNALIGN) | (1 << B_DIV0));

  typedef struct packed {
    logic div0;
    logic unalign;
    logic unalign_multi;
    logic nocp;
    logic invpc;
    logic invstate;
    logic undef;
  } uf_events_t;
endpackage

// File: rtl/ufault_qualify.sv
module ufault_qualify
  import ufault_pkg::*;
#(
  parameter int unsigned W = UF_W
) (
  input  uf_events_t     ev,
  input  logic           div0_en,
  input  logic           unalign_en,
  output logic [W-1:0]   set_vec,
  output logic           any_set
);
  always_comb begin
    set_vec = '0;
    set_vec[B_UNDEF]   = ev.undef;
    // an undecodable instruction hides the execution-state fault
    set_vec[B_INVST]   = ev.invstate & ~ev.undef;
    set_vec[B_INVPC]   = ev.invpc;
    set_vec[B_NOCP]    = ev.nocp;
    set_vec[B_UNALIGN] = ev.unalign & (unalign_en | ev.unalign_multi);
    set_vec[B_DIV0]    = ev.div0 & div0_en;
    set_vec            = set_vec & W'(UF_IMPL_MASK);
    any_set            = |set_vec;
  end
endmodule

// File: rtl/ufault_flags.sv
module ufault_flags
  import ufault_pkg::*;
#(
  parameter int unsigned W = UF_W,
  parameter logic [W-1:0] IMPL = W'(UF_IMPL_MASK)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flags
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk) begin
        if (rst)             q <= 1'b0;
        else if (set_vec[i]) q <= 1'b1;          // set beats clear
        else if (wr && wdata[i]) q <= 1'b0;
      end
      assign flags[i] = q;
    end else begin : g_rsvd
      assign flags[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ufault_report.sv
module ufault_report
  import ufault_pkg::*;
#(
  parameter int unsigned W     = UF_W,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     set_vec,
  input  logic             any_set,
  input  logic [W-1:0]     flags,
  input  logic             rd,
  output logic [W-1:0]     rdata,
  output logic             pend,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_next;

  always_comb begin
    idx_next = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (set_vec[i]) idx_next = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      pend  <= 1'b0;
      idx   <= '0;
    end else begin
      pend <= any_set;
      if (any_set) idx   <= idx_next;
      if (rd)      rdata <= flags;
    end
  end
endmodule

// File: rtl/ufault_status.sv
module ufault_status
  import ufault_pkg::*;
#(
  parameter int unsigned W     = UF_W,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_div0,
  input  logic             ev_unalign,
  input  logic             ev_unalign_multi,
  input  logic             ev_nocp,
  input  logic             ev_invpc,
  input  logic             ev_invstate,
  input  logic             ev_undef,
  input  logic             trap_div0_en,
  input  logic             trap_unalign_en,
  input  logic             reg_wr,
  input  logic [W-1:0]     reg_wdata,
  input  logic             reg_rd,
  output logic [W-1:0]     reg_rdata,
  output logic             fault_pend,
  output logic [IDX_W-1:0] fault_idx
);
  uf_events_t   ev;
  logic [W-1:0] set_vec;
  logic         any_set;
  logic [W-1:0] flags;

  assign ev = '{div0: ev_div0, unalign: ev_unalign, unalign_multi: ev_unalign_multi,
                nocp: ev_nocp, invpc: ev_invpc, invstate: ev_invstate, undef: ev_undef};

  ufault_qualify #(.W(W)) u_qual (
    .ev(ev), .div0_en(trap_div0_en), .unalign_en(trap_unalign_en),
    .set_vec(set_vec), .any_set(any_set)
  );

  ufault_flags #(.W(W)) u_flags (
    .clk(clk), .rst(rst), .set_vec(set_vec),
    .wr(reg_wr), .wdata(reg_wdata), .flags(flags)
  );

  ufault_report #(.W(W), .IDX_W(IDX_W)) u_rep (
    .clk(clk), .rst(rst), .set_vec(set_vec), .any_set(any_set),
    .flags(flags), .rd(reg_rd), .rdata(reg_rdata),
    .pend(fault_pend), .idx(fault_idx)
  );
endmodule

// File: rtl/ufault_status_chk.sv
module ufault_status_chk
  import ufault_pkg::*;
#(
  parameter int unsigned W = UF_W
) (
  input logic         clk,
  input logic         rst,
  input logic         ev_div0,
  input logic         ev_unalign,
  input logic         ev_unalign_multi,
  input logic         ev_nocp,
  input logic         ev_invstate,
  input logic         ev_undef,
  input logic         trap_div0_en,
  input logic         reg_wr,
  input logic [W-1:0] reg_wdata,
  input logic         reg_rd,
  input logic [W-1:0] reg_rdata,
  input logic         fault_pend,
  input logic [W-1:0] flags
);
  localparam logic [W-1:0] RSVD = ~W'(UF_IMPL_MASK);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & RSVD) == '0);

  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(flags) & ~($past(reg_wr) ? $past(reg_wdata) : '0)) & ~flags) == '0);

  p_div_trap_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_div0 && trap_div0_en) |=> flags[B_DIV0]);

  p_multi_unalign_r6: assert property (@(posedge clk) disable iff (rst)
    (ev_unalign && ev_unalign_multi) |=> flags[B_UNALIGN]);

  p_invstate_hidden_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_invstate && ev_undef && !flags[B_INVST]) |=> !flags[B_INVST]);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (ev_undef && reg_wr && reg_wdata[B_UNDEF]) |=> flags[B_UNDEF]);

  p_pend_nocp_r9: assert property (@(posedge clk) disable iff (rst)
    ev_nocp |=> fault_pend);

  p_read_latency_r11: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rdata == $past(flags));
endmodule

bind ufault_status ufault_status_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ev_div0(ev_div0), .ev_unalign(ev_unalign),
  .ev_unalign_multi(ev_unalign_multi), .ev_nocp(ev_nocp),
  .ev_invstate(ev_invstate), .ev_undef(ev_undef),
  .trap_div0_en(trap_div0_en), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rd(reg_rd), .reg_rdata(reg_rdata), .fault_pend(fault_pend),
  .flags(flags)
);

// File: tb/tb_ufault_status.sv
module tb_ufault_status;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // vector: {ev[6:0] = div0,unal,multi,nocp,invpc,invst,undef ; en[1:0] = div,unal ;
  //          wdata[15:0] (always written) ; exp_flags[15:0] ; exp_pend}
  localparam logic [41:0] VEC [NV] = '{
    {7'b1000000, 2'b00, 16'h0000, 16'h0000, 1'b0}, // R5 gated off
    {7'b1000000, 2'b10, 16'h0000, 16'h0200, 1'b1}, // R5 enabled, R1 bit 9
    {7'b0100000, 2'b00, 16'h0000, 16'h0200, 1'b0}, // R6 gated off, R9 no pulse
    {7'b0110000, 2'b00, 16'h0000, 16'h0300, 1'b1}, // R6 multi-word overrides
    {7'b0000000, 2'b00, 16'h0100, 16'h0200, 1'b0}, // R4 clear one bit, R3 bit 9 kept
    {7'b0100000, 2'b01, 16'h0000, 16'h0300, 1'b1}, // R6 enabled
    {7'b0000011, 2'b00, 16'h0000, 16'h0301, 1'b1}, // R7 invstate hidden
    {7'b0000010, 2'b00, 16'h0000, 16'h0303, 1'b1}, // R1 bit 1
    {7'b0001000, 2'b00, 16'h0000, 16'h030B, 1'b1}, // R1 bit 3
    {7'b0000100, 2'b00, 16'h0000, 16'h030F, 1'b1}, // R1 bit 2
    {7'b0000000, 2'b00, 16'hFFFF, 16'h0000, 1'b0}, // R4 clear all, R2
    {7'b0000001, 2'b00, 16'h0001, 16'h0001, 1'b1}, // R8 set beats clear
    {7'b0000000, 2'b00, 16'h0000, 16'h0001, 1'b0}, // R4 zeros have no effect
    {7'b0000000, 2'b00, 16'hFCF0, 16'h0001, 1'b0}  // R2 reserved-only write
  };

  logic clk = 1'b0, rst = 1'b1;
  logic ev_div0 = 0, ev_unalign = 0, ev_unalign_multi = 0, ev_nocp = 0;
  logic ev_invpc = 0, ev_invstate = 0, ev_undef = 0;
  logic trap_div0_en = 0, trap_unalign_en = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic fault_pend;
  logic [3:0] fault_idx;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ufault_status dut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_ev(input logic [6:0] e);
    {ev_div0, ev_unalign, ev_unalign_multi, ev_nocp, ev_invpc, ev_invstate, ev_undef} = e;
  endtask

  task automatic read_chk(input string req, input logic [15:0] exp);
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    check(req, reg_rdata, exp);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 pend", 16'(fault_pend), 16'h0);
    check("R10 idx", 16'(fault_idx), 16'h0);
    check("R10 rdata", reg_rdata, 16'h0);
    read_chk("R10 flags", 16'h0000);

    for (int i = 0; i < NV; i++) begin
      set_ev(VEC[i][41:35]);
      {trap_div0_en, trap_unalign_en} = VEC[i][34:33];
      reg_wr = 1'b1;
      reg_wdata = VEC[i][32:17];
      @(negedge clk);
      set_ev('0);
      reg_wr = 1'b0;
      reg_wdata = '0;
      check($sformatf("R9 vec%0d pend", i), 16'(fault_pend), 16'(VEC[i][0]));
      read_chk($sformatf("R3/R4 vec%0d flags", i), VEC[i][16:1]);
      if (i == 9) check("R12 idx bit2", 16'(fault_idx), 16'd2);
    end

    // R9: pulse lasts one cycle only
    ev_nocp = 1'b1;
    @(negedge clk);
    ev_nocp = 1'b0;
    check("R9 pend high", 16'(fault_pend), 16'h1);
    @(negedge clk);
    check("R9 pend drops", 16'(fault_pend), 16'h0);
    check("R12 idx nocp", 16'(fault_idx), 16'd3);

    // R12: simultaneous events pick lowest index, then hold
    trap_div0_en = 1'b1;
    ev_div0 = 1'b1; ev_invpc = 1'b1; ev_unalign = 1'b1; ev_unalign_multi = 1'b1;
    @(negedge clk);
    set_ev('0);
    check("R12 idx lowest", 16'(fault_idx), 16'd2);
    ev_div0 = 1'b1;
    @(negedge clk);
    ev_div0 = 1'b0;
    check("R12 idx div0", 16'(fault_idx), 16'd9);
    @(negedge clk);
    check("R12 idx holds", 16'(fault_idx), 16'd9);

    // R11: rdata holds without a read
    read_chk("R11 read", 16'h030D);
    ev_invstate = 1'b1;
    @(negedge clk);
    ev_invstate = 1'b0;
    @(negedge clk);
    check("R11 rdata held", reg_rdata, 16'h030D);
    read_chk("R11 reread", 16'h030F);

    // R10 reset with flags set
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 pend after rst", 16'(fault_pend), 16'h0);
    check("R10 idx after rst", 16'(fault_idx), 16'h0);
    check("R10 rdata after rst", reg_rdata, 16'h0);
    read_chk("R10 flags after rst", 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule